// File: doc/BRIEF.md
# Five-Level Priority Interrupt Controller

This block holds five sticky interrupt request cells and picks one of them by fixed priority, cell 0 first. A one-cycle pulse on a request input sets its cell, and the cell stays set until software kills it or a general reset arrives. A latch strobe copies the winning cell's code (cell index plus one, with 0 meaning nothing pending) into a service register. While that register is non-zero no further interrupt is raised, so interrupts do not nest until a clear strobe empties it.

The interrupt request output goes to a microsequencer. It is raised only when all of these hold: a cell is pending, the service register is empty, the one-instruction inhibit is clear, and the general inhibit is clear. A separate strobe puts a vector address on a read bus. That address is a fixed base plus four times the service code.

There are two inhibits. The first is set when an overflow check finds a 16-bit write-bus value whose top two bits differ, and a separate strobe clears it. The second is set and released by a pair of software strobes, and general reset also sets it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `req_pulse[i]` sets cell i at the next clock edge. The cell stays set on later cycles until a kill strobe selects it or a general reset occurs.
- R2: The encoder gives the index plus one of the lowest-numbered pending cell, so cell 0 wins over all others. It gives 0 when no cell is pending.
- R3: `irq` is 1 exactly when a cell is pending, the service register is 0, the one-instruction inhibit is clear and the general inhibit is clear.
- R4: While `vec_rd_stb` is 1, `rd_bus` equals 1024 (octal 2000) plus the service register value times 4, in the same cycle. At all other times `rd_bus` is 0.
- R5: `gen_rst` clears the service register, sets the general inhibit and clears all five cells at the next edge. It overrides latch, clear, release and request pulses in the same cycle. It leaves the one-instruction inhibit unchanged.
- R6: `latch_stb` loads the encoder output into the service register at the next edge.
- R7: `kill_stb` clears the cell whose index is the service register value minus one. It has no effect while the service register is 0. A request pulse for the same cell in the same cycle wins, and the cell stays set.
- R8: `clear_stb` sets the service register to 0. When it coincides with `latch_stb`, the register becomes 0.
- R9: `ovf_chk_stb` sets the one-instruction inhibit when `wr_bus[15]` differs from `wr_bus[14]`, and otherwise leaves it unchanged. `ovf_clr_stb` clears it, but a set in the same cycle wins.
- R10: `inh_set_stb` sets the general inhibit and `inh_rel_stb` clears it. If both arrive in the same cycle, the inhibit is set.
- R11: After the asynchronous reset, the service register is 0, all cells are clear, the one-instruction inhibit is clear and the general inhibit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pulse | input | 5 | One-cycle request pulses, bit i sets cell i |
| gen_rst | input | 1 | General reset strobe |
| latch_stb | input | 1 | Load encoder output into service register |
| kill_stb | input | 1 | Clear the cell being serviced |
| clear_stb | input | 1 | Empty the service register |
| ovf_chk_stb | input | 1 | Check write bus for overflow |
| ovf_clr_stb | input | 1 | Clear the one-instruction inhibit |
| inh_set_stb | input | 1 | Set the general inhibit |
| inh_rel_stb | input | 1 | Release the general inhibit |
| vec_rd_stb | input | 1 | Drive the vector address onto the read bus |
| wr_bus | input | 16 | Write bus examined by the overflow check |
| irq | output | 1 | Interrupt request to the sequencer |
| rd_bus | output | 16 | Read bus carrying the vector address |

## Verification
Every strobe and request pulse is registered once. So cell, service register and inhibit changes show up one clock edge after the strobe cycle, and `irq` follows in that same later cycle because it is built from those registers without delay. `rd_bus` depends only on the current service register and `vec_rd_stb`, so it is due in the strobe's own cycle. The bench drives inputs just after a falling edge. It reads `rd_bus` a few nanoseconds later, before the next rising edge, and reads registered results at the falling edge after that rising edge. State that has no port of its own (the cells and the service code) is brought out by a latch followed by a vector read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DEF_CELLS     = 5;
  localparam int unsigned DEF_BUS_W     = 16;
  localparam int unsigned DEF_VEC_BASE  = 1024;
  localparam int unsigned DEF_VEC_SHIFT = 2;
endpackage

// File: rtl/irq_cells.sv
module irq_cells #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_rst,
  input  logic [N-1:0]  set_i,
  input  logic          kill_stb,
  input  logic [CW-1:0] kill_sel,
  output logic [N-1:0]  pend_o,
  output logic [CW-1:0] code_o
);
  logic [N-1:0] cells_q, cells_d, kill_hit;

  for (genvar g = 0; g < N; g++) begin : g_kill
    assign kill_hit[g] = kill_stb && (kill_sel == CW'(g + 1));
  end

  always_comb begin
    if (gen_rst) cells_d = '0;
    else         cells_d = (cells_q & ~kill_hit) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells_q <= '0;
    else        cells_q <= cells_d;
  end

  // lowest index wins: scan downward so the last hit is the smallest index
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cells_q[i]) code_o = CW'(i + 1);
    end
  end

  assign pend_o = cells_q;
endmodule

// File: rtl/irq_svc.sv
module irq_svc #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_rst,
  input  logic          latch_stb,
  input  logic          clear_stb,
  input  logic [CW-1:0] code_i,
  output logic [CW-1:0] svc_o
);
  logic [CW-1:0] svc_q, svc_d;
  logic          svc_en;

  assign svc_en = gen_rst | latch_stb | clear_stb;

  always_comb begin
    if (gen_rst || clear_stb) svc_d = '0;
    else                      svc_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svc_q <= '0;
    else if (svc_en) svc_q <= svc_d;
  end

  assign svc_o = svc_q;
endmodule

// File: rtl/irq_inhibit.sv
module irq_inhibit (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_rst,
  input  logic inh_set_stb,
  input  logic inh_rel_stb,
  input  logic ovf_chk_stb,
  input  logic ovf_seen,
  input  logic ovf_clr_stb,
  output logic inh_o,
  output logic inh1_o
);
  logic inh_q, inh_d, inh1_q, inh1_d;

  always_comb begin
    inh_d = inh_q;
    if (inh_rel_stb)                inh_d = 1'b0;
    if (inh_set_stb || gen_rst)     inh_d = 1'b1;
    inh1_d = inh1_q;
    if (ovf_clr_stb)                inh1_d = 1'b0;
    if (ovf_chk_stb && ovf_seen)    inh1_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q  <= 1'b1;
      inh1_q <= 1'b0;
    end else begin
      inh_q  <= inh_d;
      inh1_q <= inh1_d;
    end
  end

  assign inh_o  = inh_q;
  assign inh1_o = inh1_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_CELLS = DEF_CELLS,
  parameter int unsigned BUS_W     = DEF_BUS_W,
  parameter int unsigned VEC_BASE  = DEF_VEC_BASE,
  parameter int unsigned VEC_SHIFT = DEF_VEC_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CELLS-1:0] req_pulse,
  input  logic                 gen_rst,
  input  logic                 latch_stb,
  input  logic                 kill_stb,
  input  logic                 clear_stb,
  input  logic                 ovf_chk_stb,
  input  logic                 ovf_clr_stb,
  input  logic                 inh_set_stb,
  input  logic                 inh_rel_stb,
  input  logic                 vec_rd_stb,
  input  logic [BUS_W-1:0]     wr_bus,
  output logic                 irq,
  output logic [BUS_W-1:0]     rd_bus
);
  localparam int unsigned CODE_W = $clog2(NUM_CELLS + 1);

  logic [NUM_CELLS-1:0] pend;
  logic [CODE_W-1:0]    enc_code, svc_q;
  logic                 inh_q, inh1_q, ovf_seen;

  assign ovf_seen = wr_bus[BUS_W-1] ^ wr_bus[BUS_W-2];

  irq_cells #(.N(NUM_CELLS), .CW(CODE_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .gen_rst(gen_rst), .set_i(req_pulse),
    .kill_stb(kill_stb), .kill_sel(svc_q), .pend_o(pend), .code_o(enc_code)
  );

  irq_svc #(.CW(CODE_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .gen_rst(gen_rst), .latch_stb(latch_stb),
    .clear_stb(clear_stb), .code_i(enc_code), .svc_o(svc_q)
  );

  irq_inhibit u_inh (
    .clk(clk), .rst_n(rst_n), .gen_rst(gen_rst), .inh_set_stb(inh_set_stb),
    .inh_rel_stb(inh_rel_stb), .ovf_chk_stb(ovf_chk_stb), .ovf_seen(ovf_seen),
    .ovf_clr_stb(ovf_clr_stb), .inh_o(inh_q), .inh1_o(inh1_q)
  );

  assign irq = (enc_code != '0) && (svc_q == '0) && !inh1_q && !inh_q;

  always_comb begin
    if (vec_rd_stb) rd_bus = BUS_W'(VEC_BASE) + (BUS_W'(svc_q) << VEC_SHIFT);
    else            rd_bus = '0;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = 3,
  parameter int unsigned BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gen_rst,
  input logic          latch_stb,
  input logic          clear_stb,
  input logic          kill_stb,
  input logic          ovf_chk_stb,
  input logic          inh_set_stb,
  input logic [BW-1:0] wr_bus,
  input logic          irq,
  input logic [N-1:0]  pend,
  input logic [CW-1:0] code,
  input logic [CW-1:0] svc,
  input logic          inh,
  input logic          inh1
);
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_rst && !kill_stb) |=> ((pend & $past(pend)) == $past(pend)));

  assert_code_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) == (code == '0));

  assert_irq_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (svc == '0 && !inh && !inh1 && pend != '0));

  assert_genrst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rst |=> (svc == '0 && inh && pend == '0 && !irq));

  assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_stb && !clear_stb && !gen_rst) |=> (svc == $past(code)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_stb |=> (svc == '0));

  assert_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_chk_stb && (wr_bus[BW-1] != wr_bus[BW-2])) |=> inh1);

  assert_inh_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inh_set_stb |=> inh);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.N(NUM_CELLS), .CW(CODE_W), .BW(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_rst(gen_rst), .latch_stb(latch_stb),
  .clear_stb(clear_stb), .kill_stb(kill_stb), .ovf_chk_stb(ovf_chk_stb),
  .inh_set_stb(inh_set_stb), .wr_bus(wr_bus), .irq(irq), .pend(pend),
  .code(enc_code), .svc(svc_q), .inh(inh_q), .inh1(inh1_q)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req_pulse = '0;
  logic        gen_rst = 0, latch_stb = 0, kill_stb = 0, clear_stb = 0;
  logic        ovf_chk_stb = 0, ovf_clr_stb = 0, inh_set_stb = 0, inh_rel_stb = 0;
  logic        vec_rd_stb = 0;
  logic [15:0] wr_bus = '0;
  logic        irq;
  logic [15:0] rd_bus;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .gen_rst(gen_rst),
    .latch_stb(latch_stb), .kill_stb(kill_stb), .clear_stb(clear_stb),
    .ovf_chk_stb(ovf_chk_stb), .ovf_clr_stb(ovf_clr_stb),
    .inh_set_stb(inh_set_stb), .inh_rel_stb(inh_rel_stb),
    .vec_rd_stb(vec_rd_stb), .wr_bus(wr_bus), .irq(irq), .rd_bus(rd_bus)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic read_vec(output logic [15:0] v);
    #2 vec_rd_stb = 1;
    #2 v = rd_bus;
    vec_rd_stb = 0;
  endtask

  task automatic do_latch(); latch_stb = 1; tick(); latch_stb = 0; endtask
  task automatic do_kill();  kill_stb  = 1; tick(); kill_stb  = 0; endtask
  task automatic do_clear(); clear_stb = 1; tick(); clear_stb = 0; endtask
  task automatic do_req(logic [4:0] m); req_pulse = m; tick(); req_pulse = '0; endtask

  task automatic t_reset_state();
    logic [15:0] v;
    check("R11 irq after reset", irq, 0);
    read_vec(v);
    check("R11/R4 vector with empty service", v, 1024);
    #6 check("R4 rd_bus idle", rd_bus, 0);
    tick();
  endtask

  task automatic t_priority();
    logic [15:0] v;
    do_req(5'b01010);
    check("R10 irq held by general inhibit", irq, 0);
    inh_rel_stb = 1; tick(); inh_rel_stb = 0;
    check("R3 irq when all allowed", irq, 1);
    do_latch();
    read_vec(v);
    check("R2/R6 cell1 wins, code 2", v, 1032);
    check("R3 irq blocked during service", irq, 0);
    tick();
  endtask

  task automatic t_kill_next();
    logic [15:0] v;
    do_kill();
    do_clear();
    check("R8 irq after clear", irq, 1);
    do_latch();
    read_vec(v);
    check("R7 killed cell1, cell3 next", v, 1040);
    tick();
  endtask

  task automatic t_kill_idle();
    logic [15:0] v;
    do_clear();
    do_kill();
    do_latch();
    read_vec(v);
    check("R7 kill with empty service ignored", v, 1040);
    tick();
    do_kill();
    do_clear();
    check("R1 no cell pending, irq low", irq, 0);
    do_latch();
    read_vec(v);
    check("R2 empty encoder gives 0", v, 1024);
    tick();
  endtask

  task automatic t_sticky_top();
    logic [15:0] v;
    do_req(5'b10001);
    repeat (3) tick();
    do_latch();
    read_vec(v);
    check("R1/R2 cell0 held and wins", v, 1028);
    tick();
    do_kill(); do_clear(); do_latch();
    read_vec(v);
    check("R1 cell4 held", v, 1044);
    tick();
    kill_stb = 1; req_pulse = 5'b10000; tick(); kill_stb = 0; req_pulse = '0;
    do_clear(); do_latch();
    read_vec(v);
    check("R7 same-cycle set beats kill", v, 1044);
    tick();
    do_kill(); do_clear();
  endtask

  task automatic t_clear_vs_latch();
    logic [15:0] v;
    do_req(5'b00100);
    latch_stb = 1; clear_stb = 1; tick(); latch_stb = 0; clear_stb = 0;
    read_vec(v);
    check("R8 clear beats latch", v, 1024);
    check("R3 irq with cell2 pending", irq, 1);
    tick();
  endtask

  task automatic t_ovf();
    wr_bus = 16'h4000; ovf_chk_stb = 1; tick(); ovf_chk_stb = 0;
    check("R9 overflow 01 sets inhibit", irq, 0);
    ovf_clr_stb = 1; tick(); ovf_clr_stb = 0;
    check("R9 clear strobe", irq, 1);
    wr_bus = 16'hC000; ovf_chk_stb = 1; tick(); ovf_chk_stb = 0;
    check("R9 no overflow on 11", irq, 1);
    wr_bus = 16'h8000; ovf_chk_stb = 1; ovf_clr_stb = 1; tick();
    ovf_chk_stb = 0; ovf_clr_stb = 0;
    check("R9 set beats clear", irq, 0);
    ovf_clr_stb = 1; tick(); ovf_clr_stb = 0;
    check("R9 cleared again", irq, 1);
    wr_bus = '0;
  endtask

  task automatic t_inh_both();
    inh_set_stb = 1; inh_rel_stb = 1; tick(); inh_set_stb = 0; inh_rel_stb = 0;
    check("R10 set beats release", irq, 0);
    inh_rel_stb = 1; tick(); inh_rel_stb = 0;
    check("R10 release", irq, 1);
  endtask

  task automatic t_genrst();
    logic [15:0] v;
    do_req(5'b00001);
    gen_rst = 1; latch_stb = 1; req_pulse = 5'b00010; tick();
    gen_rst = 0; latch_stb = 0; req_pulse = '0;
    read_vec(v);
    check("R5 service cleared over latch", v, 1024);
    check("R5 irq low after general reset", irq, 0);
    tick();
    inh_rel_stb = 1; tick(); inh_rel_stb = 0;
    check("R5 cells cleared", irq, 0);
    do_latch();
    read_vec(v);
    check("R5 encoder empty", v, 1024);
    tick();
  endtask

  initial begin
    repeat (2) tick();
    rst_n = 1;
    tick();
    t_reset_state();
    t_priority();
    t_kill_next();
    t_kill_idle();
    t_sticky_top();
    t_clear_vs_latch();
    t_ovf();
    t_inh_both();
    t_genrst();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule